// File: doc/BRIEF.md
# Shift-Left-Word Execute Stage

This block is the execute stage for a 32-bit logical left shift on a datapath with 64-bit general-purpose registers. Each cycle it may accept one raw 32-bit instruction word together with two 64-bit operand values already read from the register file: the value to be shifted and the value that holds the shift count. It decodes the word and checks whether it is the shift-left-word instruction. It then produces the 64-bit value to write back, the index of the destination register, a write enable, and an optional condition-register field 0 update.

The shift count is the low six bits of the count operand. Counts from 32 to 63 yield zero. The 32-bit result is always zero-extended to 64 bits. When the record flag in the instruction is set, the 32-bit result is classified as a signed number: negative, positive or zero. The summary-overflow bit is copied from an input into the same field.

A word that does not match still produces an output slot, but nothing is written. The outputs sit behind a single register stage with a plain valid bit.

Top module: `slw_exec_unit`

## Requirements
- R1: A word matches only when bits [31:26] equal 31 and bits [10:1] equal 24 (all-zero register fields give 32'h7C000030). A valid non-matching word yields out_valid high with out_rd_we and out_cr0_we both low.
- R2: out_rd_idx carries instruction bits [20:16] (destination register). The record flag is instruction bit [0].
- R3: Only bits [5:0] of in_rb_val form the shift count. Any value in bits [63:6] has no effect on any output.
- R4: For a count of 0 to 31, out_result[31:0] equals in_rs_val[31:0] shifted left by the count, with zeros entering at bit 0 and bits shifted past bit 31 discarded.
- R5: For a count of 32 to 63, out_result is zero.
- R6: out_result[63:32] is always zero.
- R7: out_cr0 is {LT,GT,EQ,SO} in bits [3:0]. LT is set when result bit 31 is set, EQ when the 32-bit result is zero, and GT otherwise, so exactly one of the three is set. SO equals in_xer_so. out_cr0_we is high only for a matching word whose record flag is 1.
- R8: Outputs appear on the clock edge after the one that sampled in_valid high. A cycle with in_valid low yields out_valid, out_rd_we and out_cr0_we low on the next edge.
- R9: A synchronous active-high rst clears out_valid, out_rd_we and out_cr0_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| in_instr | input | 32 | Raw instruction word |
| in_rs_val | input | 64 | Value to be shifted |
| in_rb_val | input | 64 | Value holding the shift count |
| in_xer_so | input | 1 | Current summary-overflow flag |
| out_valid | output | 1 | Result slot valid |
| out_rd_idx | output | 5 | Destination register index |
| out_result | output | 64 | Zero-extended shift result |
| out_rd_we | output | 1 | Destination write enable |
| out_cr0 | output | 4 | {LT,GT,EQ,SO} field |
| out_cr0_we | output | 1 | Condition field 0 write enable |

## Verification
Every result, the index, both enables and the condition field are due exactly one clock edge after the edge that samples the stimulus. The bench drives inputs on the falling edge and pushes the model's prediction into a queue. On the next falling edge it pops the prediction and compares it with the outputs, so each prediction is checked exactly one edge later. Reset is checked the same way: the outputs are sampled on the falling edge after the reset edge.

// File: rtl/slw_pkg.sv
package slw_pkg;

    localparam int INSTR_W = 32;
    localparam int IDX_W   = 5;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cr_field_t;

    typedef struct packed {
        logic [IDX_W-1:0] dst_idx;
        logic             rec;
    } slw_fields_t;

endpackage

// File: rtl/slw_decode.sv
module slw_decode
    import slw_pkg::*;
#(
    parameter int PRI_OP = 31,
    parameter int EXT_OP = 24
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               hit,
    output slw_fields_t        fields
);
    localparam int PRI_W = 6;
    localparam int EXT_W = 10;
    localparam logic [PRI_W-1:0] PRI_CODE = PRI_W'(PRI_OP);
    localparam logic [EXT_W-1:0] EXT_CODE = EXT_W'(EXT_OP);

    logic [PRI_W-1:0] pri_f;
    logic [EXT_W-1:0] ext_f;

    always_comb begin
        pri_f          = instr[31:26];
        ext_f          = instr[10:1];
        hit            = (pri_f == PRI_CODE) && (ext_f == EXT_CODE);
        fields.dst_idx = instr[20:16];
        fields.rec     = instr[0];
    end
endmodule

// File: rtl/slw_shifter.sv
module slw_shifter #(
    parameter int XLEN  = 64,
    parameter int WLEN  = 32,
    parameter int CNT_W = 6
) (
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] cnt_src,
    output logic [WLEN-1:0] word,
    output logic [XLEN-1:0] wide
);
    localparam int STG = $clog2(WLEN);

    logic [CNT_W-1:0] cnt;
    logic [WLEN-1:0]  stage [STG+1];
    logic             over;

    assign cnt      = cnt_src[CNT_W-1:0];
    assign stage[0] = src[WLEN-1:0];

    for (genvar i = 0; i < STG; i++) begin : g_stage
        localparam int SH = 1 << i;
        assign stage[i+1] = cnt[i] ? (stage[i] << SH) : stage[i];
    end

    if (CNT_W > STG) begin : g_over
        assign over = |cnt[CNT_W-1:STG];
    end else begin : g_no_over
        assign over = 1'b0;
    end

    assign word = over ? '0 : stage[STG];
    assign wide = {{(XLEN-WLEN){1'b0}}, word};
endmodule

// File: rtl/slw_cr_eval.sv
module slw_cr_eval
    import slw_pkg::*;
#(
    parameter int WLEN = 32
) (
    input  logic [WLEN-1:0] word,
    input  logic            so_in,
    output cr_field_t       cr
);
    always_comb begin
        cr.lt = word[WLEN-1];
        cr.eq = (word == '0);
        cr.gt = !word[WLEN-1] && (word != '0);
        cr.so = so_in;
    end
endmodule

// File: rtl/slw_exec_unit.sv
module slw_exec_unit
    import slw_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int WLEN  = 32,
    parameter int CNT_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [INSTR_W-1:0]  in_instr,
    input  logic [XLEN-1:0]     in_rs_val,
    input  logic [XLEN-1:0]     in_rb_val,
    input  logic                in_xer_so,
    output logic                out_valid,
    output logic [IDX_W-1:0]    out_rd_idx,
    output logic [XLEN-1:0]     out_result,
    output logic                out_rd_we,
    output logic [3:0]          out_cr0,
    output logic                out_cr0_we
);
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [XLEN-1:0]  result;
        logic             rd_we;
        cr_field_t        cr;
        logic             cr_we;
    } stage_t;

    stage_t          st_d, st_q;
    logic            dec_hit;
    slw_fields_t     dec_fields;
    logic [WLEN-1:0] sh_word;
    logic [XLEN-1:0] sh_wide;
    cr_field_t       cr_calc;

    slw_decode u_decode (
        .instr  (in_instr),
        .hit    (dec_hit),
        .fields (dec_fields)
    );

    slw_shifter #(.XLEN(XLEN), .WLEN(WLEN), .CNT_W(CNT_W)) u_shift (
        .src     (in_rs_val),
        .cnt_src (in_rb_val),
        .word    (sh_word),
        .wide    (sh_wide)
    );

    slw_cr_eval #(.WLEN(WLEN)) u_cr (
        .word  (sh_word),
        .so_in (in_xer_so),
        .cr    (cr_calc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.rd_we = 1'b0;
        st_d.cr_we = 1'b0;
        if (in_valid) begin
            st_d.idx    = dec_fields.dst_idx;
            st_d.result = sh_wide;
            st_d.cr     = cr_calc;
            st_d.rd_we  = dec_hit;
            st_d.cr_we  = dec_hit && dec_fields.rec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_rd_idx = st_q.idx;
    assign out_result = st_q.result;
    assign out_rd_we  = st_q.rd_we;
    assign out_cr0    = st_q.cr;
    assign out_cr0_we = st_q.cr_we;
endmodule

// File: rtl/slw_exec_unit_chk.sv
module slw_exec_unit_chk #(
    parameter int XLEN  = 64,
    parameter int WLEN  = 32,
    parameter int CNT_W = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [31:0]     in_instr,
    input logic [XLEN-1:0] in_rs_val,
    input logic [XLEN-1:0] in_rb_val,
    input logic            in_xer_so,
    input logic            out_valid,
    input logic [4:0]      out_rd_idx,
    input logic [XLEN-1:0] out_result,
    input logic            out_rd_we,
    input logic [3:0]      out_cr0,
    input logic            out_cr0_we
);
    localparam int STG = $clog2(WLEN);

    logic in_match, in_over, in_zero_cnt;
    assign in_match    = (in_instr[31:26] == 6'd31) && (in_instr[10:1] == 10'd24);
    assign in_over     = |in_rb_val[CNT_W-1:STG];
    assign in_zero_cnt = (in_rb_val[CNT_W-1:0] == '0);

    p_nomatch_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_match) |=> (out_valid && !out_rd_we && !out_cr0_we));

    p_dst_idx_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_rd_idx == $past(in_instr[20:16])));

    p_zero_count_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_zero_cnt) |=> (out_result[WLEN-1:0] == $past(in_rs_val[WLEN-1:0])));

    p_over_range_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_over) |=> (out_result == '0));

    p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_result[XLEN-1:WLEN] == '0));

    p_cr_class_r7: assert property (@(posedge clk) disable iff (rst)
        out_cr0_we |-> ($countones(out_cr0[3:1]) == 1 && out_rd_we));

    p_cr_so_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_cr0[0] == $past(in_xer_so)));

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_rd_we && !out_cr0_we));

    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !out_rd_we && !out_cr0_we));
endmodule

bind slw_exec_unit slw_exec_unit_chk #(.XLEN(XLEN), .WLEN(WLEN), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/slw_exec_unit_bench.sv
module slw_exec_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_instr;
    logic [63:0] in_rs_val, in_rb_val;
    logic        in_xer_so;
    logic        out_valid;
    logic [4:0]  out_rd_idx;
    logic [63:0] out_result;
    logic        out_rd_we;
    logic [3:0]  out_cr0;
    logic        out_cr0_we;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    typedef struct {
        bit          valid;
        bit [4:0]    idx;
        bit [63:0]   result;
        bit          we;
        bit [3:0]    cr;
        bit          cr_we;
        int          cnt;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    slw_exec_unit u_slw_exec_unit (
        .clk, .rst, .in_valid, .in_instr, .in_rs_val, .in_rb_val, .in_xer_so,
        .out_valid, .out_rd_idx, .out_result, .out_rd_we, .out_cr0, .out_cr0_we
    );

    function automatic bit [31:0] mk(input int rs, input int ra, input int rb, input bit rc);
        return {6'd31, 5'(rs), 5'(ra), 5'(rb), 10'd24, rc};
    endfunction

    function automatic exp_t model(input bit v, input bit [31:0] ins, input bit [63:0] rs,
                                   input bit [63:0] rb, input bit so);
        exp_t e;
        bit   hit;
        int   c;
        bit [31:0] w;
        c   = int'(rb % 64);
        hit = (ins >> 26) == 31 && ((ins >> 1) & 10'h3FF) == 24;
        w   = (c < 32) ? (rs[31:0] << c) : 32'd0;
        e.valid  = v;
        e.idx    = ins[20:16];
        e.result = {32'd0, w};
        e.we     = v && hit;
        e.cr_we  = v && hit && ins[0];
        e.cr     = {w[31], (!w[31] && w != 0), (w == 0), so};
        e.cnt    = c;
        return e;
    endfunction

    task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_front();
        exp_t e;
        e = exp_q.pop_front();
        cmp("R8", "out_valid", 64'(out_valid), 64'(e.valid));
        cmp("R1", "out_rd_we", 64'(out_rd_we), 64'(e.we));
        cmp("R7", "out_cr0_we", 64'(out_cr0_we), 64'(e.cr_we));
        if (e.valid) begin
            cmp("R2", "out_rd_idx", 64'(out_rd_idx), 64'(e.idx));
            cmp(e.cnt < 32 ? "R4" : "R5", "out_result", out_result, e.result);
            cmp("R6", "upper half", 64'(out_result[63:32]), 64'd0);
            cmp("R7", "out_cr0", 64'(out_cr0), 64'(e.cr));
        end
    endtask

    task automatic step(input bit v, input bit [31:0] ins, input bit [63:0] rs,
                        input bit [63:0] rb, input bit so);
        @(negedge clk);
        if (exp_q.size() > 0) check_front();
        in_valid  = v;
        in_instr  = ins;
        in_rs_val = rs;
        in_rb_val = rb;
        in_xer_so = so;
        exp_q.push_back(model(v, ins, rs, rb, so));
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_instr = '0; in_rs_val = '0; in_rb_val = '0; in_xer_so = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        cmp("R9", "reset out_valid", 64'(out_valid), 64'd0);
        cmp("R9", "reset out_rd_we", 64'(out_rd_we), 64'd0);
        cmp("R9", "reset out_cr0_we", 64'(out_cr0_we), 64'd0);
        rst = 1'b0;

        // R4: counts 0, 1, 31
        step(1, mk(3, 7, 4, 1), 64'hDEAD_BEEF_1234_5678, 64'd0, 0);
        step(1, mk(1, 2, 3, 1), 64'h0000_0000_4000_0001, 64'd1, 1);
        step(1, mk(1, 31, 3, 1), 64'h0000_0000_0000_0001, 64'd31, 0);
        // R5: counts 32 and 63
        step(1, mk(1, 4, 3, 1), 64'hFFFF_FFFF_FFFF_FFFF, 64'd32, 1);
        step(1, mk(1, 5, 3, 0), 64'hFFFF_FFFF_FFFF_FFFF, 64'd63, 0);
        // R3: high count bits ignored
        step(1, mk(2, 6, 3, 1), 64'h0000_0000_0000_00F0, 64'hFFFF_FFFF_FFFF_FF04, 0);
        step(1, mk(2, 8, 3, 1), 64'h0000_0000_1234_5678, 64'h0000_0000_0000_0040, 0);
        // R7: LT on 0x80000000, EQ on zero, GT positive, SO copied
        step(1, mk(2, 9, 3, 1), 64'h0000_0000_0000_0001, 64'd31, 1);
        step(1, mk(2, 10, 3, 1), 64'h0000_0000_0000_0000, 64'd5, 1);
        step(1, mk(2, 11, 3, 1), 64'h0000_0000_0000_0003, 64'd2, 0);
        // R6: upper source bits do not leak
        step(1, mk(2, 12, 3, 0), 64'hFFFF_FFFF_0000_0001, 64'd0, 0);
        // R1: base encoding and near-miss encodings
        step(1, 32'h7C00_0030, 64'h5, 64'd1, 0);
        step(1, mk(2, 13, 3, 1) ^ 32'h0400_0000, 64'h5, 64'd1, 0);
        step(1, mk(2, 14, 3, 1) ^ 32'h0000_0002, 64'h5, 64'd1, 1);
        // R8: idle gaps
        step(0, mk(2, 15, 3, 1), 64'h5, 64'd1, 0);
        step(1, mk(2, 16, 3, 1), 64'h7, 64'd3, 0);
        step(0, 32'h0, 64'h0, 64'd0, 0);
        // Mixed stream
        for (int i = 0; i < 300; i++) begin
            bit [31:0] ins;
            ins = mk(int'($urandom % 32), int'($urandom % 32), int'($urandom % 32), 1'($urandom));
            if ($urandom % 8 == 0) ins = $urandom;
            step(1'($urandom % 4 != 0), ins, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
        end
        step(0, 32'h0, 64'h0, 64'd0, 0);
        @(negedge clk);
        check_front();

        // R9: reset while a valid word is presented
        in_valid = 1'b1; in_instr = mk(1, 2, 3, 1); in_rs_val = 64'h1; in_rb_val = 64'h1;
        rst = 1'b1;
        @(negedge clk);
        cmp("R9", "reset out_valid", 64'(out_valid), 64'd0);
        cmp("R9", "reset out_rd_we", 64'(out_rd_we), 64'd0);
        cmp("R9", "reset out_cr0_we", 64'(out_cr0_we), 64'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule